// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a compact processor that finishes every instruction in one clock period. In that period it fetches the word addressed by the program counter, decodes it, reads two source registers, computes a result and writes that result back. It also computes the next program counter. It recognises seven operations, in three 32-bit encodings whose operation code always sits in bits 31:26:

- word load and word store;
- load-upper-immediate;
- add-immediate and register add;
- branch-if-equal;
- absolute jump.

Every other encoding passes through as an idle step.

The core holds its own instruction store and data store. Both are word-indexed. The instruction store is filled through a valid/ready load port, which accepts beats only while the core is held in reset. The rule for back-pressure is simple. `load_ready` is high for exactly as long as `rst_n` is low. A beat is taken on a rising edge where `load_valid` and `load_ready` are both high. While the core runs, `load_ready` stays low, so every offered beat stalls and nothing is written.

The data store can be read at any time through a combinational peek port. The current program counter and the register write of the current instruction are shown on plain status pins. A test environment can therefore follow execution step by step.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0, all registers read as zero and every data-store word is cleared to zero. The first instruction executed after release is the one at byte address 0.
- R2: Word load (opcode 0x23) writes register rt with the data word at address rs + sign-extended imm[15:0]. Word store (opcode 0x2b) writes rt to that same address. The data store is indexed by address bits [2 +: log2(DMEM_WORDS)], and negative offsets are honoured.
- R3: Load-upper-immediate (opcode 0x0f) writes rt with {imm[15:0], 16'h0000}.
- R4: Add-immediate (opcode 0x08) writes rt with rs + sign-extended imm. Register add (opcode 0x00, funct[5:0] 0x20) writes rd (bits 15:11) with rs + rt. Both wrap modulo 2^32 on overflow.
- R5: Branch-if-equal (opcode 0x04) sets PC to PC+4+(sign-extended imm << 2) when rs equals rt, and to PC+4 otherwise. PC is always word aligned.
- R6: Jump (opcode 0x02) sets PC to {PC+4 bits [31:28], instr[25:0], 2'b00}.
- R7: Register 0 reads as zero. A write aimed at it is discarded and never shows on `rf_we_o`.
- R8: An unknown opcode, or opcode 0x00 with a funct other than 0x20, writes no register and no memory, and advances PC by 4.
- R9: `load_ready` is high only while `rst_n` is low. A beat offered while the core runs is not written to the instruction store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; also opens the load port |
| load_valid | input | 1 | Load beat offered |
| load_ready | output | 1 | Load beat can be accepted (high during reset only) |
| load_addr | input | log2(IMEM_WORDS) | Instruction-store word index of the beat |
| load_data | input | 32 | Instruction word of the beat |
| peek_addr | input | log2(DMEM_WORDS) | Data-store word index to read |
| peek_data | output | 32 | Data-store word at `peek_addr` |
| pc_o | output | 32 | Byte address of the instruction now executing |
| rf_we_o | output | 1 | Current instruction writes a register this cycle |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value being written |

## Verification
The bench runs a program that follows a taken branch and an untaken branch, then a jump, and ends in a branch loop onto itself. A core that computes branch targets from PC instead of PC+4, or that drops the offset scaling, leaves the expected PC trace at once. An add-immediate with a negative value, a store and a load with negative offsets, and an add whose sum overflows show up as wrong write data if sign extension or wraparound is broken. A write aimed at register 0, an add reading a register that was never written, an unknown opcode and an unknown funct each show up as extra or missing register writes. An instruction-store write offered while the core runs would change the looping instruction and so the trace.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JMP   = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LUI   = 6'h0f;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2b;
  localparam logic [5:0] FN_ADD   = 6'h20;

  typedef enum logic [1:0] { BSRC_REG, BSRC_SEXT, BSRC_UPPER } bsrc_e;
  typedef enum logic       { ALU_ADD, ALU_PASSB } alu_op_e;
  typedef enum logic [1:0] { NXT_SEQ, NXT_BEQ, NXT_JMP } next_sel_e;

  typedef struct packed {
    logic      reg_write;
    logic      dest_rd;
    logic      mem_write;
    logic      mem_to_reg;
    bsrc_e     bsrc;
    alu_op_e   alu_op;
    next_sel_e next_sel;
  } ctrl_t;
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{reg_write: 1'b0, dest_rd: 1'b0, mem_write: 1'b0, mem_to_reg: 1'b0,
             bsrc: BSRC_REG, alu_op: ALU_ADD, next_sel: NXT_SEQ};
    case (opcode)
      OP_RTYPE: if (funct == FN_ADD) begin
        ctrl.reg_write = 1'b1;
        ctrl.dest_rd   = 1'b1;
      end
      OP_ADDI: begin
        ctrl.reg_write = 1'b1;
        ctrl.bsrc      = BSRC_SEXT;
      end
      OP_LUI: begin
        ctrl.reg_write = 1'b1;
        ctrl.bsrc      = BSRC_UPPER;
        ctrl.alu_op    = ALU_PASSB;
      end
      OP_LW: begin
        ctrl.reg_write  = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.bsrc       = BSRC_SEXT;
      end
      OP_SW: begin
        ctrl.mem_write = 1'b1;
        ctrl.bsrc      = BSRC_SEXT;
      end
      OP_BEQ:  ctrl.next_sel = NXT_BEQ;
      OP_JMP:  ctrl.next_sel = NXT_JMP;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            eq
);
  always_comb begin
    case (op)
      ALU_PASSB: y = b;
      default:   y = a + b;
    endcase
    eq = (a == b);
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RIDX_W-1:0] ra1,
  input  logic [RIDX_W-1:0] ra2,
  output logic [XLEN-1:0]   rd1,
  output logic [XLEN-1:0]   rd2,
  input  logic              we,
  input  logic [RIDX_W-1:0] wa,
  input  logic [XLEN-1:0]   wd
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/sc_wordmem.sv
module sc_wordmem #(
  parameter int WORDS          = 64,
  parameter int WIDTH          = 32,
  parameter bit CLEAR_ON_RESET = 1'b0,
  localparam int AW            = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] mem [WORDS];

  generate
    if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we) begin
          mem[waddr] <= wdata;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
      end
    end
  endgenerate

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_valid,
  output logic                          load_ready,
  input  logic [$clog2(IMEM_WORDS)-1:0] load_addr,
  input  logic [31:0]                   load_data,
  input  logic [$clog2(DMEM_WORDS)-1:0] peek_addr,
  output logic [31:0]                   peek_data,
  output logic [31:0]                   pc_o,
  output logic                          rf_we_o,
  output logic [4:0]                    rf_waddr_o,
  output logic [31:0]                   rf_wdata_o
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0]   pc, pc_next, pc_plus4, br_target, jmp_target;
  logic [XLEN-1:0]   instr, unused_fetch;
  logic [XLEN-1:0]   sext, upper, src_a, src_b, rt_val, alu_y, ld_data, wb_data;
  logic [RIDX_W-1:0] rs, rt, rd, waddr;
  logic              alu_eq, wb_en, load_fire;
  ctrl_t             ctrl;

  // Load port: open only while held in reset
  assign load_ready = !rst_n;
  assign load_fire  = load_valid && load_ready;

  sc_wordmem #(.WORDS(IMEM_WORDS), .WIDTH(XLEN), .CLEAR_ON_RESET(1'b0)) imem_i (
    .clk(clk), .rst_n(rst_n),
    .we(load_fire), .waddr(load_addr), .wdata(load_data),
    .raddr_a(pc[2 +: IAW]), .rdata_a(instr),
    .raddr_b(load_addr), .rdata_b(unused_fetch)
  );

  // Field extraction
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign sext  = {{16{instr[15]}}, instr[15:0]};
  assign upper = {instr[15:0], 16'h0000};

  sc_decoder dec_i (.opcode(instr[31:26]), .funct(instr[5:0]), .ctrl(ctrl));

  sc_regfile rf_i (
    .clk(clk), .rst_n(rst_n),
    .ra1(rs), .ra2(rt), .rd1(src_a), .rd2(rt_val),
    .we(wb_en), .wa(waddr), .wd(wb_data)
  );

  always_comb begin
    case (ctrl.bsrc)
      BSRC_SEXT:  src_b = sext;
      BSRC_UPPER: src_b = upper;
      default:    src_b = rt_val;
    endcase
  end

  sc_alu alu_i (.a(src_a), .b(src_b), .op(ctrl.alu_op), .y(alu_y), .eq(alu_eq));

  sc_wordmem #(.WORDS(DMEM_WORDS), .WIDTH(XLEN), .CLEAR_ON_RESET(1'b1)) dmem_i (
    .clk(clk), .rst_n(rst_n),
    .we(ctrl.mem_write), .waddr(alu_y[2 +: DAW]), .wdata(rt_val),
    .raddr_a(alu_y[2 +: DAW]), .rdata_a(ld_data),
    .raddr_b(peek_addr), .rdata_b(peek_data)
  );

  // Write-back
  assign waddr   = ctrl.dest_rd ? rd : rt;
  assign wb_data = ctrl.mem_to_reg ? ld_data : alu_y;
  assign wb_en   = ctrl.reg_write && (waddr != '0);

  // Next PC
  assign pc_plus4   = pc + 32'd4;
  assign br_target  = pc_plus4 + {sext[XLEN-3:0], 2'b00};
  assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};

  always_comb begin
    case (ctrl.next_sel)
      NXT_BEQ: pc_next = alu_eq ? br_target : pc_plus4;
      NXT_JMP: pc_next = jmp_target;
      default: pc_next = pc_plus4;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_next;
  end

  assign pc_o       = pc;
  assign rf_we_o    = wb_en;
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = wb_data;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        load_ready,
  input logic [31:0] pc_o,
  input logic        rf_we_o,
  input logic [4:0]  rf_waddr_o,
  input logic [31:0] rf_wdata_o,
  input logic [5:0]  opcode
);
  assert_pc_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pc_o == 32'd0));

  assert_lui_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o && opcode == OP_LUI) |-> (rf_wdata_o[15:0] == 16'h0000));

  assert_pc_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o[1:0] == 2'b00);

  assert_jump_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_JMP) |=> (pc_o[31:28] == 4'(($past(pc_o) + 32'd4) >> 28)));

  assert_no_r0_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (rf_waddr_o != 5'd0));

  assert_seq_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode != OP_BEQ && opcode != OP_JMP) |=> (pc_o == $past(pc_o) + 32'd4));

  assert_load_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ready);
endmodule

bind sc_core sc_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .load_ready(load_ready), .pc_o(pc_o),
  .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
  .opcode(instr[31:26])
);

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;
  localparam int IW = 64;
  localparam int DW = 64;
  localparam int NCYC = 40;

  typedef struct {
    logic [31:0] pc;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [5:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [5:0]  peek_addr = '0;
  logic [31:0] peek_data, pc_o, rf_wdata_o;
  logic        rf_we_o;
  logic [4:0]  rf_waddr_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  exp_t exp_q[$];
  logic [31:0] prog [IW];

  always #4 clk = ~clk;

  sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
    .load_addr(load_addr), .load_data(load_data), .peek_addr(peek_addr),
    .peek_data(peek_data), .pc_o(pc_o), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o)
  );

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: reference model pushes the expected per-cycle trace
  task automatic drive_expected();
    logic [31:0] rf [32];
    logic [31:0] dm [DW];
    logic [31:0] pc = 0;
    foreach (rf[i]) rf[i] = 0;
    foreach (dm[i]) dm[i] = 0;
    for (int c = 0; c < NCYC; c++) begin
      logic [31:0] ins = prog[pc[7:2]];
      logic [5:0]  op = ins[31:26];
      logic [4:0]  s = ins[25:21], t = ins[20:16], d = ins[15:11];
      logic [31:0] se = {{16{ins[15]}}, ins[15:0]};
      logic [31:0] a = rf[s], b = rf[t], nxt = pc + 4, val = 0, ea = a + se;
      logic [4:0]  dst = 0;
      logic        wr = 0;
      exp_t        it;
      string       tg = "R8";
      case (op)
        6'h00: if (ins[5:0] == 6'h20) begin wr = 1; dst = d; val = a + b; tg = "R4"; end
        6'h08: begin wr = 1; dst = t; val = a + se; tg = "R4"; end
        6'h0f: begin wr = 1; dst = t; val = {ins[15:0], 16'h0}; tg = "R3"; end
        6'h23: begin wr = 1; dst = t; val = dm[ea[7:2]]; tg = "R2"; end
        6'h2b: begin dm[ea[7:2]] = b; tg = "R2"; end
        6'h04: begin if (a == b) nxt = pc + 4 + {se[29:0], 2'b00}; tg = "R5"; end
        6'h02: begin nxt = {nxt[31:28], ins[25:0], 2'b00}; tg = "R6"; end
        default: ;
      endcase
      if (wr && dst == 0) begin wr = 0; tg = "R7"; end
      it.pc = pc; it.we = wr; it.wa = wr ? dst : 5'd0; it.wd = wr ? val : 32'd0; it.tag = tg;
      exp_q.push_back(it);
      if (wr) rf[dst] = val;
      pc = nxt;
    end
  endtask

  // Monitor: pops expected items and compares once per cycle
  task automatic monitor();
    for (int c = 0; c < NCYC; c++) begin
      exp_t it = exp_q.pop_front();
      #1;
      n_chk++;
      if (pc_o !== it.pc || rf_we_o !== it.we ||
          (it.we && (rf_waddr_o !== it.wa || rf_wdata_o !== it.wd))) begin
        n_bad++;
        $display("FAIL %s cycle %0d: actual pc=%h we=%b r%0d=%h expected pc=%h we=%b r%0d=%h",
                 it.tag, c, pc_o, rf_we_o, rf_waddr_o, rf_wdata_o, it.pc, it.we, it.wa, it.wd);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    foreach (prog[i]) prog[i] = 32'h0;
    prog[0]  = enc_i(6'h0f, 0, 1, 16'h1234);   // lui r1 (R3)
    prog[1]  = enc_i(6'h08, 0, 2, 16'h7fff);   // addi r2 (R4)
    prog[2]  = enc_i(6'h08, 0, 3, 16'hfffc);   // addi r3 negative (R4)
    prog[3]  = enc_r(2, 3, 4, 6'h20);          // add r4 (R4)
    prog[4]  = enc_i(6'h0f, 0, 5, 16'h8000);   // lui r5
    prog[5]  = enc_r(5, 5, 6, 6'h20);          // add wraps to 0 (R4)
    prog[6]  = enc_i(6'h08, 2, 0, 16'h0005);   // write to r0 dropped (R7)
    prog[7]  = enc_r(15, 2, 7, 6'h20);         // r15 clear after reset (R1)
    prog[8]  = enc_i(6'h2b, 0, 1, 16'h0008);   // sw (R2)
    prog[9]  = enc_i(6'h08, 0, 8, 16'h0010);
    prog[10] = enc_i(6'h2b, 8, 2, 16'hfffc);   // sw negative offset (R2)
    prog[11] = enc_i(6'h23, 8, 9, 16'hfff8);   // lw (R2)
    prog[12] = 32'hfc21_0010;                  // unknown opcode (R8)
    prog[13] = enc_r(2, 3, 10, 6'h22);         // unknown funct (R8)
    prog[14] = enc_i(6'h04, 2, 3, 16'h0005);   // beq not taken (R5)
    prog[15] = enc_i(6'h04, 2, 7, 16'h0002);   // beq taken (R5)
    prog[16] = enc_i(6'h08, 0, 11, 16'h0001);
    prog[17] = enc_i(6'h08, 0, 11, 16'h0002);
    prog[18] = {6'h02, 26'd21};                // j (R6)
    prog[19] = enc_i(6'h08, 0, 12, 16'h0009);
    prog[20] = enc_i(6'h08, 0, 12, 16'h0009);
    prog[21] = enc_i(6'h08, 0, 13, 16'h0003);
    prog[22] = enc_i(6'h04, 0, 0, 16'hffff);   // loop on itself (R5)

    drive_expected();

    @(negedge clk);
    check("R1", "pc in reset", pc_o, 32'd0);
    check("R9", "ready in reset", {31'd0, load_ready}, 32'd1);
    for (int i = 0; i < IW; i++) begin
      load_valid = 1'b1; load_addr = 6'(i); load_data = prog[i];
      @(negedge clk);
    end
    load_valid = 1'b0;
    rst_n = 1'b1;
    fork
      monitor();
      begin
        repeat (25) @(negedge clk);
        load_valid = 1'b1; load_addr = 6'd22; load_data = enc_i(6'h08, 0, 14, 16'h0007);
        #1 check("R9", "ready while running", {31'd0, load_ready}, 32'd0);
        repeat (3) @(negedge clk);
        load_valid = 1'b0;
      end
    join
    peek_addr = 6'd2; #1 check("R2", "dmem[2]", peek_data, 32'h1234_0000);
    peek_addr = 6'd3; #1 check("R2", "dmem[3]", peek_data, 32'h0000_7fff);
    peek_addr = 6'd4; #1 check("R1", "dmem[4] cleared", peek_data, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    done = 1;
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule